// File: doc/BRIEF.md
# Eight-Channel ADC Continuous Scan Controller

This block is the control side of an eight-input analog-to-digital converter. Once enabled it starts conversions on the inputs in a fixed cyclic order, 0 through 7 and back to 0, and never stops on its own. Each finished conversion lands in that channel's result register, so after the first pass every register is refreshed once per eight conversion periods. The analog core sits outside. The block sends it a one-cycle start pulse and a channel number, and the core answers with a one-cycle done pulse and a result byte.

Two software-visible bits gate the controller. An enable bit powers the converter. A source bit moves the core from the system clock to an internal free-running oscillator. Each of these needs a settling interval before a result can be trusted: a short one after enabling, and a long one after the move to the internal oscillator. Both intervals are counted in system-clock cycles derived from a clock-frequency parameter. Entering a light (wait) or deep (stop) low-power state abandons the conversion in flight and keeps the scan position. On return, that channel is converted again. A deep-state exit without the external exit delay also gets the short settling interval.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `conv_start` is 0, `res_valid` is all zeros and `use_int_clk` is 0.
- R2: While `pwr_en` is 0, no start pulse is issued. On the cycle after `pwr_en` is seen low, every bit of `res_valid` is 0.
- R3: After `pwr_en` rises, the first start pulse comes no sooner than PWR cycles (100 us of system clock) and no later than PWR+4 cycles.
- R4: Start pulses walk the channels 0,1,...,7,0,1,... in `conv_chan`. The first conversion after each enable is channel 0.
- R5: A done pulse for a live conversion writes `conv_data` into byte `chan` of `res_data` (bits chan*8 up to chan*8+7) and sets bit `chan` of `res_valid`. Conversion N+8 overwrites the byte written by conversion N.
- R6: `conv_start` is a one-cycle pulse, and a second start is never issued before the running conversion has ended (done, or abandoned).
- R7: A 0-to-1 change of `clk_sel` abandons the running conversion. The same channel is started again no sooner than CLK cycles (10 ms of system clock) and no later than CLK+4 cycles.
- R8: While `lp_wait` or `lp_stop` is high, no start pulse is issued and the running conversion is abandoned. After `lp_wait` falls, the held channel starts again within 4 cycles.
- R9: After `lp_stop` falls with `stop_exit_dly` at 0, the held channel restarts after PWR to PWR+4 cycles. With `stop_exit_dly` at 1 it restarts within 4 cycles.
- R10: A done pulse that arrives while the block is suspended leaves `res_data` and `res_valid` unchanged.
- R11: `use_int_clk` equals the value `clk_sel` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Converter enable |
| clk_sel | input | 1 | 1 selects the internal oscillator for the core |
| lp_stop | input | 1 | Deep low-power request |
| lp_wait | input | 1 | Light low-power request |
| stop_exit_dly | input | 1 | 1 when the deep-state exit already includes a settling delay |
| conv_done | input | 1 | One-cycle pulse from the core: result ready |
| conv_data | input | DATA_W | Result byte qualified by `conv_done` |
| conv_start | output | 1 | One-cycle pulse asking the core to convert |
| conv_chan | output | CH_W | Channel for the current conversion |
| use_int_clk | output | 1 | Registered clock-source selection for the core |
| res_data | output | NUM_CH*DATA_W | Result registers, channel k at bits k*DATA_W upward |
| res_valid | output | NUM_CH | Per-channel result-present flags |

## Verification
The properties assume that the core raises `conv_done` for exactly one cycle, only after a start, and never after it has been told (by suspension, a source change or disable) that its conversion is void. The bench's core model follows this. It answers every start a fixed latency later, and the test tasks cancel the model's pending answer at the same moment they assert a low-power request, raise `clk_sel` or drop `pwr_en`. The one stray done pulse is injected on purpose while the block is suspended, where the design must drop it. All control inputs change half a period away from the sampling edge and stay steady for many cycles.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SQ_OFF  = 2'd0,
        SQ_IDLE = 2'd1,
        SQ_BUSY = 2'd2
    } seq_state_e;

    // Settling interval in system-clock cycles, rounded up.
    function automatic longint settle_cycles(input longint clk_hz, input longint wait_us);
        return (clk_hz * wait_us + 64'd999_999) / 64'd1_000_000;
    endfunction

    function automatic longint max_cyc(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input longint v);
        int w;
        w = 1;
        while ((64'd1 << w) <= v) w++;
        return w;
    endfunction

endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             settled
);
    logic [CNT_W-1:0] remain;

    // A new request never shortens a wait already in progress.
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load_en) begin
            remain <= (load_val > remain) ? load_val : remain;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign settled = (remain == '0) && !load_en;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_en,
    input  logic            suspend,
    input  logic            reclock,
    input  logic            settled,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] chan,
    output logic            wr_en
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    seq_state_e      state;
    logic            start_q;
    logic [CH_W-1:0] chan_q;
    logic            go;
    logic            abort;

    function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] c);
        return (c == LAST_CH) ? '0 : c + 1'b1;
    endfunction

    assign abort = suspend || reclock;
    assign go    = (state == SQ_IDLE) && pwr_en && !abort && settled;
    assign wr_en = (state == SQ_BUSY) && pwr_en && !abort && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_OFF;
            start_q <= 1'b0;
            chan_q  <= '0;
        end else begin
            start_q <= go;
            if (!pwr_en) begin
                state  <= SQ_OFF;
                chan_q <= '0;
            end else begin
                unique case (state)
                    SQ_OFF: begin
                        state  <= SQ_IDLE;
                        chan_q <= '0;
                    end
                    SQ_IDLE: begin
                        if (go) state <= SQ_BUSY;
                    end
                    SQ_BUSY: begin
                        if (abort) begin
                            state <= SQ_IDLE;
                        end else if (conv_done) begin
                            state  <= SQ_IDLE;
                            chan_q <= next_chan(chan_q);
                        end
                    end
                    default: state <= SQ_OFF;
                endcase
            end
        end
    end

    assign conv_start = start_q;
    assign chan       = chan_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    parameter int CH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0]        rd_valid
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        logic              vld_q;
        logic              hit;

        assign hit = wr_en && (wr_chan == CH_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                if (hit) slot_q <= wr_data;
                if (clear)    vld_q <= 1'b0;
                else if (hit) vld_q <= 1'b1;
            end
        end

        assign rd_data[g*DATA_W +: DATA_W] = slot_q;
        assign rd_valid[g]                 = vld_q;
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter longint SYS_CLK_HZ   = 200_000_000,
    parameter longint PWR_SETTLE_US = 100,
    parameter longint OSC_SETTLE_US = 10_000,
    parameter int     NUM_CH       = 8,
    parameter int     DATA_W       = 8,
    parameter int     CH_W         = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pwr_en,
    input  logic                     clk_sel,
    input  logic                     lp_stop,
    input  logic                     lp_wait,
    input  logic                     stop_exit_dly,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic                     conv_start,
    output logic [CH_W-1:0]          conv_chan,
    output logic                     use_int_clk,
    output logic [NUM_CH*DATA_W-1:0] res_data,
    output logic [NUM_CH-1:0]        res_valid
);
    localparam longint PWR_CYC = settle_cycles(SYS_CLK_HZ, PWR_SETTLE_US);
    localparam longint OSC_CYC = settle_cycles(SYS_CLK_HZ, OSC_SETTLE_US);
    localparam int     CNT_W   = width_for(max_cyc(PWR_CYC, OSC_CYC));
    localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_CYC);
    localparam logic [CNT_W-1:0] OSC_LD = CNT_W'(OSC_CYC);

    logic pwr_q, sel_q, stop_q;
    logic pwr_rise, sel_rise, stop_slow_exit;
    logic suspend;
    logic load_en;
    logic [CNT_W-1:0] load_val;
    logic settled;
    logic wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q  <= 1'b0;
            sel_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            pwr_q  <= pwr_en;
            sel_q  <= clk_sel;
            stop_q <= lp_stop;
        end
    end

    assign pwr_rise       = pwr_en && !pwr_q;
    assign sel_rise       = clk_sel && !sel_q;
    assign stop_slow_exit = stop_q && !lp_stop && !stop_exit_dly;
    assign suspend        = lp_stop || lp_wait;

    always_comb begin
        load_val = '0;
        if (pwr_rise || stop_slow_exit) load_val = PWR_LD;
        if (sel_rise && (OSC_LD > load_val)) load_val = OSC_LD;
    end
    assign load_en = pwr_rise || stop_slow_exit || sel_rise;

    adc_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .settled  (settled)
    );

    adc_scan_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pwr_en     (pwr_en),
        .suspend    (suspend),
        .reclock    (sel_rise),
        .settled    (settled),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .chan       (conv_chan),
        .wr_en      (wr_en)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clear    (!pwr_en),
        .wr_en    (wr_en),
        .wr_chan  (conv_chan),
        .wr_data  (conv_data),
        .rd_data  (res_data),
        .rd_valid (res_valid)
    );

    assign use_int_clk = sel_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
    parameter int     NUM_CH  = 8,
    parameter longint PWR_CYC = 100
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_en,
    input logic              clk_sel,
    input logic              lp_stop,
    input logic              lp_wait,
    input logic              conv_start,
    input logic              use_int_clk,
    input logic [NUM_CH-1:0] res_valid
);
    // Cycles since pwr_en went high, saturating at the settle length.
    longint on_cnt;
    always_ff @(posedge clk) begin
        if (rst || !pwr_en) on_cnt <= 0;
        else if (on_cnt < PWR_CYC + 1) on_cnt <= on_cnt + 1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!conv_start && (res_valid == '0) && !use_int_clk));

    assert_off_no_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && $past(!pwr_en)) |-> !conv_start);

    assert_off_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> (res_valid == '0));

    assert_power_settle_R3: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (on_cnt >= PWR_CYC));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_lowpower_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ((lp_stop || lp_wait) && $past(lp_stop || lp_wait)) |-> !conv_start);

    assert_clock_follow_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (use_int_clk == $past(clk_sel)));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
    .NUM_CH  (NUM_CH),
    .PWR_CYC (PWR_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_en      (pwr_en),
    .clk_sel     (clk_sel),
    .lp_stop     (lp_stop),
    .lp_wait     (lp_wait),
    .conv_start  (conv_start),
    .use_int_clk (use_int_clk),
    .res_valid   (res_valid)
);

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
    localparam int NCH = 8;
    localparam int DW  = 8;
    localparam int PWR = 100;     // 100 us at 1 MHz
    localparam int OSC = 10000;   // 10 ms at 1 MHz
    localparam int LAT = 5;

    logic clk = 0;
    logic rst = 1;
    logic pwr_en = 0, clk_sel = 0, lp_stop = 0, lp_wait = 0, stop_exit_dly = 1;
    logic conv_done = 0;
    logic [DW-1:0] conv_data = '0;
    logic conv_start, use_int_clk;
    logic [2:0] conv_chan;
    logic [NCH*DW-1:0] res_data;
    logic [NCH-1:0] res_valid;

    always #2.5 clk = ~clk;

    adc_scan_ctrl #(.SYS_CLK_HZ(1_000_000)) uut (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .clk_sel(clk_sel),
        .lp_stop(lp_stop), .lp_wait(lp_wait), .stop_exit_dly(stop_exit_dly),
        .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .conv_chan(conv_chan), .use_int_clk(use_int_clk),
        .res_data(res_data), .res_valid(res_valid)
    );

    int checks = 0, errors = 0;
    int cyc = 0, start_cnt = 0, last_start_cyc = 0, min_gap = 1000, seqn = 0;
    int last_chan = 0;
    int hist [256];
    bit core_busy = 0, inj_done = 0;
    int core_cnt = 0, core_chan = 0;
    logic [DW-1:0] exp_d [NCH];
    bit exp_v [NCH];

    // Core model and start monitor, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        conv_done = 0;
        if (inj_done) begin
            conv_done = 1; conv_data = 8'hEE; inj_done = 0;
        end else if (core_busy) begin
            if (core_cnt == 0) begin
                conv_done = 1;
                conv_data = {core_chan[2:0], seqn[4:0]};
                exp_d[core_chan] = conv_data;
                exp_v[core_chan] = 1;
                seqn++;
                core_busy = 0;
            end else core_cnt--;
        end
        if (conv_start) begin
            if (start_cnt > 0 && (cyc - last_start_cyc) < min_gap) min_gap = cyc - last_start_cyc;
            hist[start_cnt % 256] = int'(conv_chan);
            start_cnt++;
            last_start_cyc = cyc;
            last_chan = int'(conv_chan);
            core_busy = 1; core_cnt = LAT; core_chan = int'(conv_chan);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_start(input int limit, output int dly, output bit got);
        int s0 = start_cnt;
        int c0 = cyc;
        got = 0;
        for (int i = 0; i < limit && !got; i++) begin
            @(posedge clk);
            if (start_cnt != s0) got = 1;
        end
        #1;
        dly = last_start_cyc - c0;
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1;
        chk(conv_start == 0 && res_valid == 0 && use_int_clk == 0, "R1 reset outputs",
            int'(res_valid), 0);
        rst = 0;
        @(posedge clk); #1;
        chk(conv_start == 0 && res_valid == 0, "R1 first cycle", int'(conv_start), 0);
    endtask

    task automatic t_off();
        int s0 = start_cnt;
        repeat (50) @(posedge clk);
        #1;
        chk(start_cnt == s0, "R2 no start while disabled", start_cnt - s0, 0);
    endtask

    task automatic t_powerup();
        int d; bit got;
        pwr_en = 1;
        wait_start(PWR + 20, d, got);
        chk(got && d >= PWR && d <= PWR + 4, "R3 power settle", d, PWR);
        chk(last_chan == 0, "R4 first channel after enable", last_chan, 0);
    endtask

    task automatic t_scan();
        int s0 = start_cnt - 1;
        min_gap = 1000;
        while (start_cnt < s0 + 20) @(posedge clk);
        #1;
        for (int k = 0; k < 20; k++)
            chk(hist[(s0 + k) % 256] == k % NCH, "R4 channel order", hist[(s0 + k) % 256], k % NCH);
        chk(min_gap >= LAT + 1, "R6 start spacing", min_gap, LAT + 1);
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < NCH; k++)
            chk(res_data[k*DW +: DW] == exp_d[k], "R5 result with wraparound",
                int'(res_data[k*DW +: DW]), int'(exp_d[k]));
        chk(res_valid == '1, "R5 valid flags", int'(res_valid), 255);
    endtask

    task automatic t_suspend(input bit deep, input bit dly_bit);
        int d; bit got; int c; int s0;
        logic [DW-1:0] held; logic hv;
        wait_start(100, d, got);
        c = last_chan;
        stop_exit_dly = dly_bit;
        if (deep) lp_stop = 1; else lp_wait = 1;
        core_busy = 0;
        s0 = start_cnt;
        repeat (20) @(posedge clk);
        #1;
        chk(start_cnt == s0, "R8 no start while suspended", start_cnt - s0, 0);
        held = res_data[c*DW +: DW];
        hv = res_valid[c];
        inj_done = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(res_data[c*DW +: DW] == held && res_valid[c] == hv, "R10 done ignored in suspension",
            int'(res_data[c*DW +: DW]), int'(held));
        lp_stop = 0; lp_wait = 0;
        wait_start(PWR + 20, d, got);
        if (deep && !dly_bit)
            chk(got && d >= PWR && d <= PWR + 4, "R9 settle after fast stop exit", d, PWR);
        else if (deep)
            chk(got && d <= 4, "R9 immediate after delayed stop exit", d, 1);
        else
            chk(got && d <= 4, "R8 immediate after wait exit", d, 1);
        chk(last_chan == c, deep ? "R9 same channel resampled" : "R8 same channel resampled",
            last_chan, c);
        stop_exit_dly = 1;
    endtask

    task automatic t_clksel();
        int d; bit got; int c;
        wait_start(100, d, got);
        c = last_chan;
        clk_sel = 1;
        core_busy = 0;
        wait_start(OSC + 20, d, got);
        chk(got && d >= OSC && d <= OSC + 4, "R7 oscillator settle", d, OSC);
        chk(last_chan == c, "R7 channel resampled", last_chan, c);
        chk(use_int_clk == 1, "R11 selection high", int'(use_int_clk), 1);
        clk_sel = 0;
        @(posedge clk); #1;
        chk(use_int_clk == 0, "R11 selection low", int'(use_int_clk), 0);
        wait_start(LAT + 10, d, got);
        chk(got, "R7 no wait on return to system clock", int'(got), 1);
    endtask

    task automatic t_reenable();
        int d; bit got; int s0;
        repeat (2) @(posedge clk);
        #1;
        pwr_en = 0;
        core_busy = 0;
        for (int k = 0; k < NCH; k++) exp_v[k] = 0;
        @(posedge clk); @(posedge clk); #1;
        chk(res_valid == 0, "R2 valid cleared on disable", int'(res_valid), 0);
        s0 = start_cnt;
        repeat (30) @(posedge clk);
        #1;
        chk(start_cnt == s0, "R2 quiet while disabled", start_cnt - s0, 0);
        pwr_en = 1;
        wait_start(PWR + 20, d, got);
        chk(got && d >= PWR && d <= PWR + 4, "R3 settle on re-enable", d, PWR);
        chk(last_chan == 0, "R4 restart at channel 0", last_chan, 0);
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) begin exp_d[k] = '0; exp_v[k] = 0; end
        t_reset();
        t_off();
        t_powerup();
        t_scan();
        t_suspend(1'b0, 1'b1);
        t_suspend(1'b1, 1'b0);
        t_suspend(1'b1, 1'b1);
        t_clksel();
        t_reenable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule